// File: doc/BRIEF.md
# HDLC Bit-Destuffing Frame Receiver

This block takes a recovered serial bit stream, one bit per accepted beat, and turns it into framed bytes. It finds flag octets (`01111110`) in the raw stream, removes the zero that a transmitter inserts after five ones, and packs the remaining bits into bytes, least significant bit first. At the end of each frame it checks the frame check sequence, using either the 16-bit CCITT polynomial or the 32-bit polynomial, and attaches a status word to the last byte. One flag may close one frame and open the next. Aborts, short frames, long frames, frames that end off a byte boundary and check failures are each reported separately. A level output shows when the line is idle.

Both the bit input and the byte output are valid/ready streams. A bit is consumed on a clock edge where `in_valid` and `in_ready` are both high. An output beat is taken on an edge where `out_valid` and `out_ready` are both high. While a beat waits with `out_ready` low, the beat stays stable and `in_ready` is low, so no input bit is lost and no byte is dropped. The input valid signal therefore also works as the bit-enable of the recovered clock. The configuration inputs are read continuously and must be held stable while a frame is open.

A frame's check bytes are removed from the output by default. The keep-check option passes them through as ordinary data bytes. In bit-synchronous PPP mode the abort run is fifteen ones; in HDLC mode it is seven.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: A frame opens on a flag and closes on the next flag. Flags with no bits between them produce no output beat.
- R2: Inside a frame, a 0 bit that follows exactly five consecutive 1 bits is discarded and does not count as data.
- R3: Data bits are packed into bytes least significant bit first. `out_sof` is high on the first beat of a frame and `out_eof` on its last beat, and each frame produces exactly one `out_eof` beat.
- R4: The check runs over all of a frame's bytes, including the check sequence, starting from an all-ones register with a reflected polynomial. The residue must be 0xF0B8 for the 16-bit check (`cfg_crc32`=0) or 0xDEBB20E3 for the 32-bit check (`cfg_crc32`=1). If it is not, status bit 0 (check error) is set on the closing beat.
- R5: With `cfg_crc_keep`=0 the last 2 or 4 bytes (the check bytes) are not output. With `cfg_crc_keep`=1 they are output as ordinary data bytes.
- R6: With `cfg_ppp`=0, a run of seven 1 bits inside a frame ends the frame. It emits one beat with data 0x00, `out_eof`=1 and status 0x02 (bit 1, abort), and the bits that follow are ignored until the next flag.
- R7: With `cfg_ppp`=1, the abort run is fifteen 1 bits, and runs of seven to fourteen ones produce no beat.
- R8: A frame whose total byte count is no larger than the check length (2 or 4) sets status bit 2 (short) and never sets status bit 0. With `cfg_crc_keep`=0 it is reported as a single beat with data 0x00.
- R9: A frame whose total byte count, check bytes included, exceeds `cfg_max_len` sets status bit 3 (long) on its closing beat.
- R10: A frame whose bit count is not a multiple of eight sets status bit 4 (alignment) on its closing beat and does not set status bit 0.
- R11: A single flag both closes the frame before it and opens the frame after it.
- R12: `line_idle` rises after fifteen consecutive accepted 1 bits and falls after the next accepted 0 bit.
- R13: While `out_valid` is high and `out_ready` is low, the output beat is held stable and `in_ready` is low.
- R14: `out_status` is zero on every beat that does not carry `out_eof`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A received bit is offered |
| in_ready | output | 1 | The offered bit will be taken on this edge |
| in_bit | input | 1 | Received line bit |
| cfg_crc32 | input | 1 | 1: 32-bit check, 0: 16-bit check |
| cfg_crc_keep | input | 1 | 1: check bytes are output as data |
| cfg_ppp | input | 1 | 1: bit-synchronous PPP abort run of fifteen ones |
| cfg_max_len | input | LEN_W (12) | Largest legal frame size in bytes, check bytes included |
| out_valid | output | 1 | An output beat is present |
| out_ready | input | 1 | Sink accepts the beat |
| out_data | output | 8 | Frame byte |
| out_sof | output | 1 | First beat of a frame |
| out_eof | output | 1 | Last beat of a frame; status is valid |
| out_status | output | 5 | {align, long, short, abort, check error} |
| line_idle | output | 1 | Fifteen or more ones seen since the last zero |

## Verification
The bench sweeps frame lengths and byte patterns over both check widths and both check-handling options, with back-pressure, and chains the frames on shared flags. Runs of all-ones and flag-valued bytes force stuffing across byte boundaries. A design that counts the run of ones wrongly would either emit a spurious flag or keep a stuffed zero, and both break every following byte. Closing on a shared flag exercises the six-bit lookbehind: a receiver that releases bits too early puts part of the flag into the last byte, and one that forgets to reopen the frame loses the next frame. The abort runs are placed just below and just above the threshold in each mode. The short, long and off-boundary frames check that each status bit is set alone, that the check error is suppressed where it means nothing, and that a short frame still ends in exactly one closing beat.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

  localparam int STAT_W = 5;

  // Packed from MSB to LSB: bit 4 alignment ... bit 0 check error
  typedef struct packed {
    logic align;
    logic long_f;
    logic short_f;
    logic abort;
    logic crc_err;
  } rx_stat_t;

  localparam logic [31:0] POLY16 = 32'h0000_8408;
  localparam logic [31:0] POLY32 = 32'hEDB8_8320;
  localparam logic [31:0] RES16  = 32'h0000_F0B8;
  localparam logic [31:0] RES32  = 32'hDEBB_20E3;
  localparam logic [31:0] SEED16 = 32'h0000_FFFF;
  localparam logic [31:0] SEED32 = 32'hFFFF_FFFF;

  // One reflected check step; the narrow form keeps the upper half clear
  function automatic logic [31:0] crc_bit_step(logic [31:0] c, logic b, logic wide);
    logic [31:0] n;
    logic        fb;
    fb = c[0] ^ b;
    n  = c >> 1;
    if (fb) n = n ^ (wide ? POLY32 : POLY16);
    if (!wide) n[31:16] = '0;
    return n;
  endfunction

endpackage

// File: rtl/hdlc_rx_linestate.sv
module hdlc_rx_linestate #(
  parameter int ONES_W     = 4,
  parameter int STUFF_RUN  = 5,
  parameter int HDLC_ABORT = 7,
  parameter int PPP_ABORT  = 15,
  parameter int IDLE_RUN   = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic bit_in,
  input  logic ppp_mode,
  output logic ev_data,
  output logic ev_flag,
  output logic ev_abort,
  output logic line_idle
);
  localparam int ONES_MAX = (1 << ONES_W) - 1;

  logic [ONES_W-1:0] ones_q, ones_d;
  logic [ONES_W:0]   ones_inc;
  int                abort_run;

  always_comb begin
    ones_inc  = {1'b0, ones_q} + 1'b1;
    abort_run = ppp_mode ? PPP_ABORT : HDLC_ABORT;
    // Below the stuffing run every bit is payload (or a flag prefix)
    ev_data   = bit_en && (int'(ones_q) < STUFF_RUN);
    ev_flag   = bit_en && !bit_in && (int'(ones_q) == STUFF_RUN + 1);
    ev_abort  = bit_en && bit_in && (int'(ones_inc) == abort_run);
    if (!bit_in)                             ones_d = '0;
    else if (int'(ones_q) == ONES_MAX)       ones_d = ones_q;
    else                                     ones_d = ones_inc[ONES_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ones_q    <= '0;
      line_idle <= 1'b0;
    end else if (bit_en) begin
      ones_q    <= ones_d;
      line_idle <= (int'(ones_d) >= IDLE_RUN);
    end
  end

endmodule

// File: rtl/hdlc_rx_crc.sv
module hdlc_rx_crc
  import hdlc_rx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic init,
  input  logic step,
  input  logic bit_in,
  input  logic wide,
  output logic match
);
  logic [31:0] crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     crc_q <= SEED32;
    else if (init)  crc_q <= wide ? SEED32 : SEED16;
    else if (step)  crc_q <= crc_bit_step(crc_q, bit_in, wide);
  end

  assign match = wide ? (crc_q == RES32) : (crc_q[15:0] == RES16[15:0]);

endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
  import hdlc_rx_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_bit,
  input  logic             cfg_crc32,
  input  logic             cfg_crc_keep,
  input  logic             cfg_ppp,
  input  logic [LEN_W-1:0] cfg_max_len,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_sof,
  output logic             out_eof,
  output logic [STAT_W-1:0] out_status,
  output logic             line_idle
);
  // Bits appended after a zero may still be a flag prefix: 0 + five ones
  localparam int FLAG_TAIL = 6;
  localparam int MAX_CHK   = 4;
  localparam int SR_W      = FLAG_TAIL + 8 * MAX_CHK + 16;
  localparam int P_W       = $clog2(SR_W + 1);
  localparam int CNT_W     = LEN_W + 4;

  logic             acc;
  logic             ev_data, ev_flag, ev_abort;
  logic             crc_match, crc_step;
  logic             in_frame_q, sent_any_q;
  logic [SR_W-1:0]  sr_q, sr_app;
  logic [P_W-1:0]   p_q, p_app;
  logic [CNT_W-1:0] cnt_q;
  int               chk_bytes, held_bytes, thr;

  logic             b_load, b_sof, b_eof;
  logic [7:0]       b_data;
  rx_stat_t         b_stat, stat_q;

  function automatic logic [7:0] pick_byte(input logic [SR_W-1:0] v, input int top);
    logic [7:0] b;
    for (int i = 0; i < 8; i++) begin
      if ((top - 1 - i >= 0) && (top - 1 - i < SR_W)) b[i] = v[top-1-i];
      else                                            b[i] = 1'b0;
    end
    return b;
  endfunction

  assign in_ready = !out_valid || out_ready;
  assign acc      = in_valid && in_ready;

  hdlc_rx_linestate u_line (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en   (acc),
    .bit_in   (in_bit),
    .ppp_mode (cfg_ppp),
    .ev_data  (ev_data),
    .ev_flag  (ev_flag),
    .ev_abort (ev_abort),
    .line_idle(line_idle)
  );

  always_comb begin
    chk_bytes  = cfg_crc32 ? 4 : 2;
    held_bytes = cfg_crc_keep ? 0 : chk_bytes;
    thr        = FLAG_TAIL + 8 * held_bytes + 16;
    sr_app     = {sr_q[SR_W-2:0], in_bit};
    p_app      = p_q + 1'b1;
    crc_step   = acc && ev_data && in_frame_q && (int'(p_app) > FLAG_TAIL);
  end

  hdlc_rx_crc u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .init  (acc && ev_flag),
    .step  (crc_step),
    .bit_in(sr_app[FLAG_TAIL]),
    .wide  (cfg_crc32),
    .match (crc_match)
  );

  // Beat selection: abort, close on flag, or a byte released mid-frame
  always_comb begin
    b_load = 1'b0;
    b_data = '0;
    b_sof  = !sent_any_q;
    b_eof  = 1'b0;
    b_stat = '0;
    if (ev_abort && in_frame_q) begin
      b_load       = 1'b1;
      b_eof        = 1'b1;
      b_stat.abort = 1'b1;
    end else if (ev_flag && in_frame_q && (int'(p_q) > FLAG_TAIL)) begin
      b_load         = 1'b1;
      b_eof          = 1'b1;
      b_stat.align   = (cnt_q[2:0] != 3'd0);
      b_stat.short_f = (int'(cnt_q) < 8 * (chk_bytes + 1));
      b_stat.long_f  = (cnt_q[CNT_W-1:3] > {1'b0, cfg_max_len});
      b_stat.crc_err = !b_stat.short_f && !b_stat.align && !crc_match;
      if (int'(p_q) >= thr - 8) b_data = pick_byte(sr_q, int'(p_q));
    end else if (ev_data && in_frame_q && (int'(p_app) == thr)) begin
      b_load = 1'b1;
      b_data = pick_byte(sr_app, thr);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      sent_any_q <= 1'b0;
      sr_q       <= '0;
      p_q        <= '0;
      cnt_q      <= '0;
    end else if (acc) begin
      if (ev_flag) begin
        in_frame_q <= 1'b1;
        sent_any_q <= 1'b0;
        p_q        <= '0;
        cnt_q      <= '0;
      end else if (ev_abort && in_frame_q) begin
        in_frame_q <= 1'b0;
      end else if (ev_data && in_frame_q) begin
        sr_q <= sr_app;
        p_q  <= (int'(p_app) == thr) ? p_app - P_W'(8) : p_app;
        if (crc_step && (cnt_q != '1)) cnt_q <= cnt_q + 1'b1;
        if (b_load) sent_any_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
      stat_q    <= '0;
    end else if (acc && b_load) begin
      out_valid <= 1'b1;
      out_data  <= b_data;
      out_sof   <= b_sof;
      out_eof   <= b_eof;
      stat_q    <= b_stat;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign out_status = stat_q;

endmodule

// File: rtl/hdlc_rx_deframer_chk.sv
module hdlc_rx_deframer_chk #(
  parameter int LEN_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_bit,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_data,
  input logic             out_sof,
  input logic             out_eof,
  input logic [4:0]       out_status,
  input logic             line_idle,
  input logic [LEN_W-1:0] cfg_max_len
);
  // R13: a stalled beat does not move
  a_r13_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sof)
                                && $stable(out_eof) && $stable(out_status));

  // R14: status only on closing beats
  a_r14_mid_status_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_eof |-> out_status == 5'd0);

  // R6: abort beat shape
  a_r6_abort_beat: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_status[1] |-> out_eof && out_data == 8'h00
                                   && out_status[4:2] == 3'd0 && !out_status[0]);

  // R8: short frames never carry a check error
  a_r8_short_no_crc: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_status[2] |-> !out_status[0]);

  // R10: off-boundary frames never carry a check error
  a_r10_align_no_crc: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_status[4] |-> !out_status[0]);

  // R12: idle follows accepted line bits
  a_r12_idle_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_idle) |-> $past(in_valid && in_ready && in_bit));

  a_r12_idle_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_idle) |-> $past(in_valid && in_ready && !in_bit));

endmodule

bind hdlc_rx_deframer hdlc_rx_deframer_chk #(.LEN_W(LEN_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_bit     (in_bit),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .out_sof    (out_sof),
  .out_eof    (out_eof),
  .out_status (out_status),
  .line_idle  (line_idle),
  .cfg_max_len(cfg_max_len)
);

// File: tb/hdlc_rx_deframer_tb.sv
`timescale 1ns/100ps
module hdlc_rx_deframer_tb;
  localparam int LEN_W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_bit = 1'b0;
  logic cfg_crc32 = 1'b0, cfg_crc_keep = 1'b0, cfg_ppp = 1'b0;
  logic [LEN_W-1:0] cfg_max_len = 12'd255;
  logic in_ready, out_valid, out_ready, out_sof, out_eof, line_idle;
  logic [7:0] out_data;
  logic [4:0] out_status;

  always #2.5 clk = ~clk;

  hdlc_rx_deframer #(.LEN_W(LEN_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit),
    .cfg_crc32(cfg_crc32), .cfg_crc_keep(cfg_crc_keep), .cfg_ppp(cfg_ppp),
    .cfg_max_len(cfg_max_len), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof),
    .out_status(out_status), .line_idle(line_idle)
  );

  int checks = 0, failures = 0, tx_ones = 0;
  bit done = 1'b0;
  bit bp_en = 1'b0;
  logic [7:0] lfsr;

  always @(posedge clk)
    if (!rst_n) lfsr <= 8'h5A;
    else        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
  assign out_ready = !bp_en || lfsr[0] || lfsr[1];

  // beat = {sof, eof, status[4:0], data[7:0]}
  logic [14:0] got_beat [2048];
  int got_n = 0;
  logic [14:0] exp_beat [32];
  int exp_n;

  always @(negedge clk)
    if (rst_n && out_valid && out_ready && got_n < 2048) begin
      got_beat[got_n] <= {out_sof, out_eof, out_status, out_data};
      got_n <= got_n + 1;
    end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send_bit(logic b);
    @(negedge clk);
    in_valid = 1'b1;
    in_bit   = b;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic idle_wait(int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_data_bit(logic b);
    send_bit(b);
    tx_ones = b ? tx_ones + 1 : 0;
    if (tx_ones == 5) begin
      send_bit(1'b0);
      tx_ones = 0;
    end
  endtask

  task automatic send_byte(logic [7:0] v);
    for (int i = 0; i < 8; i++) send_data_bit(v[i]);
  endtask

  task automatic send_flag();
    send_bit(1'b0);
    for (int i = 0; i < 6; i++) send_bit(1'b1);
    send_bit(1'b0);
    tx_ones = 0;
  endtask

  task automatic send_ones(int n);
    for (int i = 0; i < n; i++) send_bit(1'b1);
  endtask

  function automatic logic [31:0] crc_upd(logic [31:0] c, logic b, logic w);
    logic [31:0] n;
    n = c >> 1;
    if (c[0] ^ b) n = n ^ (w ? 32'hEDB88320 : 32'h00008408);
    return n;
  endfunction

  function automatic logic [7:0] pat_byte(int pat, int i, int len);
    case (pat)
      0:       return 8'hFF;
      1:       return 8'h7E;
      default: return 8'((i * 37) + (len * 11) + 1);
    endcase
  endfunction

  // Frame body plus check bytes plus the closing (shared) flag
  task automatic send_frame(int len, int pat, bit corrupt, logic [4:0] last_stat);
    logic [7:0]  pl [16];
    logic [31:0] crc;
    int nchk, nout;
    crc  = cfg_crc32 ? 32'hFFFFFFFF : 32'h0000FFFF;
    nchk = cfg_crc32 ? 4 : 2;
    for (int i = 0; i < len; i++) begin
      pl[i] = pat_byte(pat, i, len);
      for (int k = 0; k < 8; k++) crc = crc_upd(crc, pl[i][k], cfg_crc32);
    end
    crc = ~crc;
    for (int j = 0; j < nchk; j++) pl[len+j] = crc[8*j +: 8];
    if (corrupt) pl[0][0] = ~pl[0][0];
    nout  = cfg_crc_keep ? len + nchk : len;
    exp_n = nout;
    for (int i = 0; i < nout; i++)
      exp_beat[i] = {(i == 0), (i == nout - 1), (i == nout - 1) ? last_stat : 5'd0, pl[i]};
    for (int i = 0; i < len + nchk; i++) send_byte(pl[i]);
    send_flag();
  endtask

  task automatic compare_frame(string req, int base);
    int n;
    bit ok;
    logic [14:0] a, e;
    idle_wait(40);
    n = got_n - base;
    chk(n == exp_n, req, "beat count", n, exp_n);
    if (n == exp_n) begin
      ok = 1'b1; a = '0; e = '0;
      for (int i = 0; i < n; i++)
        if (ok && got_beat[base+i] !== exp_beat[i]) begin
          ok = 1'b0; a = got_beat[base+i]; e = exp_beat[i];
        end
      chk(ok, req, "beat {sof,eof,status,data}", a, e);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state
    chk(out_valid == 1'b0, "R13", "out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R13", "in_ready after reset", in_ready, 1);
    chk(line_idle == 1'b0, "R12", "line_idle after reset", line_idle, 0);

    // R12: idle detection
    send_ones(14);
    idle_wait(1);
    chk(line_idle == 1'b0, "R12", "idle after 14 ones", line_idle, 0);
    send_ones(2);
    idle_wait(1);
    chk(line_idle == 1'b1, "R12", "idle after 16 ones", line_idle, 1);
    send_bit(1'b0);
    idle_wait(1);
    chk(line_idle == 1'b0, "R12", "idle after a zero", line_idle, 0);

    // R1: back-to-back flags emit nothing
    base = got_n;
    send_flag(); send_flag(); send_flag();
    idle_wait(20);
    chk(got_n == base, "R1", "beats from empty flags", got_n - base, 0);

    // R2 R3 R4 R5 R11 R13: sweep over check width, keep option, length, pattern
    bp_en = 1'b1;
    for (int w = 0; w < 2; w++)
      for (int kp = 0; kp < 2; kp++) begin
        cfg_crc32 = w[0]; cfg_crc_keep = kp[0];
        send_flag();
        idle_wait(5);
        for (int len = 1; len <= 6; len++)
          for (int pat = 0; pat < 3; pat++) begin
            base = got_n;
            send_frame(len, pat, 1'b0, 5'd0);
            compare_frame("R2 R3 R4 R5 R11 R13 sweep", base);
          end
      end
    bp_en = 1'b0;

    // R4: corrupted payload bit
    cfg_crc32 = 1'b0; cfg_crc_keep = 1'b0;
    send_flag();
    base = got_n;
    send_frame(3, 2, 1'b1, 5'h01);
    compare_frame("R4 check error 16", base);
    cfg_crc32 = 1'b1;
    send_flag();
    base = got_n;
    send_frame(4, 0, 1'b1, 5'h01);
    compare_frame("R4 check error 32", base);

    // R9: long frame limit on total bytes
    cfg_crc32 = 1'b0; cfg_max_len = 12'd4;
    send_flag();
    base = got_n;
    send_frame(2, 2, 1'b0, 5'h00);
    compare_frame("R9 at limit", base);
    base = got_n;
    send_frame(3, 2, 1'b0, 5'h08);
    compare_frame("R9 over limit", base);
    cfg_max_len = 12'd255;

    // R8: short frames
    send_flag();
    base = got_n;
    send_byte(8'h12); send_byte(8'h34); send_flag();
    idle_wait(20);
    exp_n = 1; exp_beat[0] = {1'b1, 1'b1, 5'h04, 8'h00};
    compare_frame("R8 short 16", base);
    cfg_crc32 = 1'b1;
    base = got_n;
    for (int i = 0; i < 4; i++) send_byte(8'(8'hA1 + i));
    send_flag();
    exp_n = 1; exp_beat[0] = {1'b1, 1'b1, 5'h04, 8'h00};
    compare_frame("R8 short 32", base);

    // R10: three extra bits before the closing flag
    cfg_crc32 = 1'b0;
    send_flag();
    base = got_n;
    begin
      logic [31:0] c;
      c = 32'h0000FFFF;
      for (int i = 0; i < 3; i++)
        for (int k = 0; k < 8; k++) c = crc_upd(c, pat_byte(2, i, 3)/*byte*/ >> k, 1'b0);
      for (int i = 0; i < 3; i++) send_byte(pat_byte(2, i, 3));
      c = ~c;
      send_byte(c[7:0]); send_byte(c[15:8]);
      send_data_bit(1'b0); send_data_bit(1'b1); send_data_bit(1'b0);
      send_flag();
    end
    idle_wait(40);
    chk(got_n - base == 3, "R10", "beats for off-boundary frame", got_n - base, 3);
    if (got_n > base)
      chk(got_beat[got_n-1][14:8] == {1'b0, 1'b1, 5'h10}, "R10", "closing {sof,eof,status}",
          got_beat[got_n-1][14:8], {1'b0, 1'b1, 5'h10});

    // R6: HDLC abort after seven ones
    cfg_ppp = 1'b0;
    send_flag();
    base = got_n;
    send_byte(8'h12); send_byte(8'h34);
    send_ones(6);
    idle_wait(10);
    chk(got_n == base, "R6", "beats after six ones", got_n - base, 0);
    send_ones(1);
    send_bit(1'b0);
    send_byte(8'h00);
    exp_n = 1; exp_beat[0] = {1'b1, 1'b1, 5'h02, 8'h00};
    compare_frame("R6 abort", base);

    // R7: PPP abort only at fifteen ones
    cfg_ppp = 1'b1;
    send_flag();
    base = got_n;
    send_byte(8'h5A);
    send_ones(14);
    idle_wait(10);
    chk(got_n == base, "R7", "beats after fourteen ones", got_n - base, 0);
    send_ones(1);
    exp_n = 1; exp_beat[0] = {1'b1, 1'b1, 5'h02, 8'h00};
    compare_frame("R7 abort", base);
    cfg_ppp = 1'b0;

    // R14: status zero on a long non-closing run already covered; explicit check
    cfg_crc_keep = 1'b1;
    send_flag();
    base = got_n;
    send_frame(5, 1, 1'b0, 5'h00);
    compare_frame("R14 keep frame", base);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule